// File: doc/BRIEF.md
# Ternary Search Word with Event-Sticky Hit

This block is one layer word of an associative-memory road. It holds a 15-bit reference pattern. The three most significant positions of that pattern can each be marked as wildcards. While the chip is in search mode, every clock compares a 15-bit hit word against the pattern in one cycle. A hit sets a flag, and the flag stays set until the event is rearmed, so the road logic above sees whether this layer was hit at any point in the event.

The pattern is loaded while search mode is off, in two phases of three clocks each. One phase writes the 15 pattern bits. The other writes the 3-bit wildcard mask. A complete load therefore takes six clocks.

Top module: `tcam_word`

## Requirements
- R1: After the asynchronous active-low reset, hit_o is 0, the stored pattern is all zeros and the wildcard mask is all zeros (no wildcard).
- R2: A search happens on a rising edge with run_i high. hit_o is 1 after that edge if srch_i equals the pattern on every non-wildcard position. The compare result appears on hit_o at the edge that samples srch_i.
- R3: Positions 0 to 11 always need an exact match. A difference on any of them gives no hit.
- R4: Mask bit j covers search bit 12+j. When that mask bit is 1, either value of that search bit matches. When it is 0, that position needs an exact match.
- R5: Once set, hit_o stays 1 through later mismatching or idle cycles until rearm.
- R6: rearm_i high at an edge clears hit_o. When rearm and a hit coincide, rearm wins, and a hit at the next edge sets hit_o again.
- R7: While run_i is low, hit_o does not change except through rearm.
- R8: A load phase starts when ld_we_i is high at an edge while run_i is low and no phase is in progress. ld_sel_i=0 selects the pattern phase, which writes ld_data_i[14:0]. ld_sel_i=1 selects the mask phase, which writes ld_data_i[2:0]. The value is stored at the third edge of the phase, and a search at the following edge uses it.
- R9: ld_we_i is ignored during the two edges after a phase start, and whenever run_i is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Search mode when high, load mode when low |
| ld_we_i | input | 1 | Starts a load phase |
| ld_sel_i | input | 1 | 0 selects the pattern phase, 1 selects the mask phase |
| ld_data_i | input | 15 | Load data |
| srch_i | input | 15 | Hit word to compare |
| rearm_i | input | 1 | Clears the sticky hit |
| hit_o | output | 1 | Sticky hit flag |

## Verification
A search or rearm sampled at an edge shows on hit_o after that same edge, so the bench drives at the falling edge and checks at the next falling edge, one cycle later. A load phase started at edge k commits at edge k+2. The bench waits three full cycles before it relies on the new contents, and it drives junk writes on edge k+1 to show they are dropped. A reference model of the pattern, the mask and the flag gives the expected value for every cycle. The stimulus mixes random loads and searches with directed wildcard, rearm and mode corner cases.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
  localparam int unsigned WORD_W  = 15;
  localparam int unsigned WILD_N  = 3;
  localparam int unsigned PHASE_C = 3;
endpackage

// File: rtl/tcam_load_seq.sv
module tcam_load_seq #(
  parameter int unsigned W  = 15,
  parameter int unsigned WN = 3,
  parameter int unsigned PC = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          we_i,
  input  logic          sel_i,
  input  logic [W-1:0]  data_i,
  output logic [W-1:0]  pat_o,
  output logic [WN-1:0] mask_o
);
  localparam int unsigned CW = (PC > 2) ? $clog2(PC) : 1;
  localparam logic [CW-1:0] LAST = CW'(PC - 2);

  logic          busy_q, sel_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  data_q, pat_q;
  logic [WN-1:0] mask_q;
  logic          start, commit;

  assign start  = we_i && !run_i && !busy_q;
  assign commit = busy_q && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sel_q  <= 1'b0;
      cnt_q  <= '0;
      data_q <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      sel_q  <= sel_i;
      cnt_q  <= '0;
      data_q <= data_i;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (commit) busy_q <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pat_q  <= '0;
      mask_q <= '0;
    end else if (commit) begin
      if (sel_q) mask_q <= data_q[WN-1:0];
      else       pat_q  <= data_q;
    end
  end

  assign pat_o  = pat_q;
  assign mask_o = mask_q;

  // R9
  busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(data_q) && $stable(sel_q));
  // R8
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> cnt_q <= LAST);
  // R8
  pat_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |=> $stable(pat_q) && $stable(mask_q));
endmodule

// File: rtl/tcam_cmp.sv
module tcam_cmp #(
  parameter int unsigned W  = 15,
  parameter int unsigned WN = 3
) (
  input  logic [W-1:0]  pat_i,
  input  logic [WN-1:0] mask_i,
  input  logic [W-1:0]  srch_i,
  output logic          hit_o
);
  localparam int unsigned WLSB = W - WN;
  logic [W-1:0] ok;

  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i >= WLSB) begin : g_wild
      assign ok[i] = mask_i[i-WLSB] | ~(pat_i[i] ^ srch_i[i]);
    end else begin : g_exact
      assign ok[i] = ~(pat_i[i] ^ srch_i[i]);
    end
  end

  assign hit_o = &ok;

  // R3
  exact_miss_chk: assert final (!(hit_o && (pat_i[WLSB-1:0] != srch_i[WLSB-1:0])));
endmodule

// File: rtl/tcam_sticky.sv
module tcam_sticky (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  input  logic hit_i,
  input  logic rearm_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               flag_q <= 1'b0;
    else if (rearm_i)          flag_q <= 1'b0;
    else if (run_i && hit_i)   flag_q <= 1'b1;
  end

  assign flag_o = flag_q;

  // R6
  rearm_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rearm_i |=> !flag_q);
  // R5
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_q && !rearm_i |=> flag_q);
  // R7
  load_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i && !flag_q |=> !flag_q);
  // R2
  hit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && hit_i && !rearm_i |=> flag_q);
endmodule

// File: rtl/tcam_word.sv
module tcam_word
  import tcam_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned WN = WILD_N,
  parameter int unsigned PC = PHASE_C
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         ld_we_i,
  input  logic         ld_sel_i,
  input  logic [W-1:0] ld_data_i,
  input  logic [W-1:0] srch_i,
  input  logic         rearm_i,
  output logic         hit_o
);
  logic [W-1:0]  pat;
  logic [WN-1:0] mask;
  logic          cmp_hit;

  tcam_load_seq #(.W(W), .WN(WN), .PC(PC)) u_load (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run_i), .we_i (ld_we_i),
    .sel_i (ld_sel_i), .data_i (ld_data_i), .pat_o (pat), .mask_o (mask)
  );

  tcam_cmp #(.W(W), .WN(WN)) u_cmp (
    .pat_i (pat), .mask_i (mask), .srch_i (srch_i), .hit_o (cmp_hit)
  );

  tcam_sticky u_flag (
    .clk_i (clk_i), .rst_ni (rst_ni), .run_i (run_i), .hit_i (cmp_hit),
    .rearm_i (rearm_i), .flag_o (hit_o)
  );

  // R9
  run_no_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && $past(run_i) && $past(run_i, 2) && $past(run_i, 3)
      |-> $stable(pat) && $stable(mask));
endmodule

// File: tb/tcam_word_test.sv
module tcam_word_test;
  logic        clk_i = 0, rst_ni = 0, run_i = 0, ld_we_i = 0, ld_sel_i = 0, rearm_i = 0;
  logic [14:0] ld_data_i = '0, srch_i = '0;
  logic        hit_o;
  int vecs = 0, errs = 0;
  logic [14:0] m_pat = '0;
  logic [2:0]  m_mask = '0;
  logic        m_flag = 0;

  always #5 clk_i = ~clk_i;

  tcam_word uut (.*);

  function automatic logic ref_hit(logic [14:0] p, logic [2:0] m, logic [14:0] s);
    logic [14:0] care;
    care = {~m, 12'hfff};
    return ((p ^ s) & care) == '0;
  endfunction

  task automatic chk(string req, logic exp);
    vecs++;
    if (hit_o !== exp) begin
      errs++;
      $display("FAIL %s: hit_o=%b expected %b", req, hit_o, exp);
    end
  endtask

  task automatic cyc(string req, logic run, logic [14:0] s, logic rr);
    @(negedge clk_i);
    run_i = run; srch_i = s; rearm_i = rr; ld_we_i = 0;
    @(negedge clk_i);
    if (rr) m_flag = 0;
    else if (run && ref_hit(m_pat, m_mask, s)) m_flag = 1;
    chk(req, m_flag);
  endtask

  task automatic load(logic sel, logic [14:0] d, logic junk);
    @(negedge clk_i);
    run_i = 0; rearm_i = 0; ld_we_i = 1; ld_sel_i = sel; ld_data_i = d;
    @(negedge clk_i);
    ld_we_i = junk; ld_sel_i = ~sel; ld_data_i = ~d;
    @(negedge clk_i);
    ld_we_i = 0;
    @(negedge clk_i);
    if (sel) m_mask = d[2:0]; else m_pat = d;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic [14:0] s;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
    chk("R1", 1'b0);
    cyc("R1", 1, 15'h0001, 0);             // zero pattern, no wildcard: miss
    cyc("R1", 1, 15'h0000, 0);             // matches reset pattern
    cyc("R6", 1, 15'h0000, 1);             // rearm beats hit
    cyc("R6", 1, 15'h0000, 0);             // hit counts next edge

    load(0, 15'h2a5c, 1);                  // junk write during phase dropped
    cyc("R6", 0, 15'h0, 1);
    cyc("R8", 1, 15'h2a5c, 0);
    cyc("R5", 1, 15'h7fff, 0);
    cyc("R5", 1, 15'h0000, 0);
    cyc("R7", 0, 15'h0, 0);
    cyc("R6", 1, 15'h0001, 1);
    cyc("R3", 1, 15'h2a5d, 0);             // bit 0 differs
    cyc("R3", 1, 15'h2e5c, 0);             // bit 10 differs
    cyc("R4", 1, 15'h6a5c, 0);             // bit 14 differs, unmasked
    cyc("R7", 0, 15'h2a5c, 0);             // load mode: no update
    load(1, 15'h0004, 0);                  // wildcard on bit 14
    cyc("R4", 1, 15'h6a5c, 0);
    cyc("R6", 1, 15'h0, 1);
    cyc("R4", 1, 15'h3a5c, 0);             // bit 12 unmasked, miss
    // R9: write attempt in run mode ignored
    @(negedge clk_i);
    run_i = 1; ld_we_i = 1; ld_sel_i = 0; ld_data_i = 15'h1111; srch_i = 15'h0; rearm_i = 1;
    @(negedge clk_i);
    ld_we_i = 0; m_flag = 0;
    chk("R9", 1'b0);
    repeat (3) cyc("R9", 1, 15'h1111, 0);
    cyc("R9", 1, 15'h2a5c, 0);

    for (int n = 0; n < 60; n++) begin
      load(0, 15'($urandom), n[0]);
      load(1, 15'($urandom), 0);
      cyc("R6", 1, 15'h0, 1);
      for (int k = 0; k < 12; k++) begin
        s = m_pat;
        if ($urandom % 3 == 0) s = s ^ 15'(1 << ($urandom % 15));
        if ($urandom % 2 == 0) s[14:12] = s[14:12] ^ (3'($urandom) & m_mask);
        cyc("R2", ($urandom % 5) != 0, s, ($urandom % 7) == 0);
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule